// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads two entries, one after the other, from a two-level translation table held in memory. A request brings the virtual address, a write flag and a user-privilege flag. When the block accepts the request it also samples the root address of the top-level directory, which comes from a base register outside the block. The block then reads the directory entry, checks it, reads the second-level entry, checks that, and joins the page frame with the page offset. If either entry is absent or denies the access, the walk stops at that level and the block reports a fault with a cause code.

The virtual address splits into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit byte offset (bits 11:0). Every entry is 4 bytes wide and uses the same layout at both levels:

| Entry bits | Meaning |
|---|---|
| 31:12 | 20-bit frame number |
| 11:3 | ignored |
| 2 | user-accessible |
| 1 | writable |
| 0 | present |

The memory side has one read port and allows only one read in flight at a time. The response stays on the outputs until the consumer accepts it.

Top module: `ptw_top`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_req` is 0.
- R2: The block accepts a request only when it is idle. While a walk is running or a response is pending, `req_ready` is 0, and a request held on the inputs during that time has no effect on the walk.
- R3: The first read of a walk goes to `dir_base + 4*vaddr[31:22]`. The value of `dir_base` used here is the one sampled at the cycle the request was accepted.
- R4: In the directory entry, bit 0 means present, bit 1 means writable and bit 2 means user-accessible. If that entry fails its check, the walk ends with a level-0 fault and no second read is issued.
- R5: The second read goes to `{pde[31:12], 12'h000} + 4*vaddr[21:12]`, where `pde` is the directory entry that was read.
- R6: The second-level entry is checked with the same bit meanings. If it fails, the walk ends with a level-1 fault after exactly two reads.
- R7: When both entries pass, `rsp_fault` is 0 and `rsp_paddr` equals `{pte[31:12], vaddr[11:0]}`.
- R8: A fault sets `rsp_fault` to 1 and `rsp_paddr` to 0. `rsp_fault_level` is 0 for the directory and 1 for the table. `rsp_fault_reason` is 1 for not present, 2 for a write to an entry without the writable bit, and 3 for a user access to an entry without the user bit. When several apply, they rank in that order: not present, then write, then user.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold their values. In the cycle after `rsp_valid` and `rsp_ready` are both 1, `rsp_valid` is 0 and `req_ready` is 1.
- R10: `mem_rd_req` is high for exactly one cycle per read. No further read is issued until `mem_rd_valid` has returned the data of the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made at user privilege |
| dir_base | input | 32 | Root address of the top-level directory |
| mem_rd_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data is returned this cycle |
| mem_rd_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result is available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_level | output | 1 | Level of the fault: 0 directory, 1 table |
| rsp_fault_reason | output | 2 | Fault cause code; 0 when there is no fault |

## Verification
The following are checked on every cycle:
- `req_ready` is exclusive with an active walk or a pending response.
- Each read is a single-cycle pulse, and no read is issued while one is outstanding.
- The first read address is built from the base and index sampled at acceptance.
- A directory fault follows exactly one read; a table fault or a success follows exactly two.
- A successful result keeps the request's offset.
- A fault result carries a nonzero cause and a zero address.
- The response holds until it is accepted.

Only the bench's scenarios can show the rest:
- That the second read address follows the frame number in the directory entry.
- That the final frame comes from the second-level entry.
- That the cause priority is right across all combinations of entry flags, write and user.
- That changing the base and request inputs during a walk leaves the result alone.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Entry flag positions, shared by both table levels
    localparam int unsigned FLAG_PRESENT  = 0;
    localparam int unsigned FLAG_WRITABLE = 1;
    localparam int unsigned FLAG_USER     = 2;
    localparam int unsigned FLAG_W        = 3;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READ_DIR = 3'd1,
        ST_WAIT_DIR = 3'd2,
        ST_READ_PT  = 3'd3,
        ST_WAIT_PT  = 3'd4,
        ST_DONE     = 3'd5,
        ST_FAULT    = 3'd6
    } walk_state_e;

    typedef enum logic [1:0] {
        RSN_NONE       = 2'd0,
        RSN_ABSENT     = 2'd1,
        RSN_READ_ONLY  = 2'd2,
        RSN_SUPERVISOR = 2'd3
    } fault_reason_e;

    typedef enum logic {
        LVL_DIR = 1'b0,
        LVL_TBL = 1'b1
    } fault_level_e;

endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic              is_write,
    input  logic              is_user,
    output fault_reason_e     reason
);

    // Absence outranks a write violation, which outranks a privilege violation
    always_comb begin
        if (!flags[FLAG_PRESENT]) begin
            reason = RSN_ABSENT;
        end else if (is_write && !flags[FLAG_WRITABLE]) begin
            reason = RSN_READ_ONLY;
        end else if (is_user && !flags[FLAG_USER]) begin
            reason = RSN_SUPERVISOR;
        end else begin
            reason = RSN_NONE;
        end
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned PA_W      = 32,
    parameter int unsigned DIR_IDX_W = 10,
    parameter int unsigned TBL_IDX_W = 10,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned ENT_LG2   = 2
) (
    input  logic [PA_W-1:0]       dir_base,
    input  logic [DIR_IDX_W-1:0]  dir_idx,
    input  logic [TBL_IDX_W-1:0]  tbl_idx,
    input  logic [OFF_W-1:0]      page_off,
    input  logic [PA_W-OFF_W-1:0] tbl_frame,
    input  logic [PA_W-OFF_W-1:0] leaf_frame,
    output logic [PA_W-1:0]       dir_entry_addr,
    output logic [PA_W-1:0]       tbl_entry_addr,
    output logic [PA_W-1:0]       phys_addr
);

    // Entry address = level base + index scaled by the entry size
    assign dir_entry_addr = dir_base + (PA_W'(dir_idx) << ENT_LG2);
    assign tbl_entry_addr = {tbl_frame, OFF_W'(0)} + (PA_W'(tbl_idx) << ENT_LG2);

    // Frame number shifted up by the page size, joined with the offset
    assign phys_addr = {leaf_frame, page_off};

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned ENTRY_W   = 32,
    parameter int unsigned DIR_IDX_W = 10,
    parameter int unsigned TBL_IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [PA_W-1:0]   dir_base,
    output logic              mem_rd_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rd_valid,
    input  logic [ENTRY_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_fault_level,
    output logic [1:0]        rsp_fault_reason
);

    localparam int unsigned OFF_W   = VA_W - DIR_IDX_W - TBL_IDX_W;
    localparam int unsigned FRAME_W = PA_W - OFF_W;
    localparam int unsigned ENT_LG2 = $clog2(ENTRY_W / 8);

    typedef struct packed {
        walk_state_e        state;
        logic [VA_W-1:0]    vaddr;
        logic               is_write;
        logic               is_user;
        logic [PA_W-1:0]    base;
        logic [FRAME_W-1:0] tbl_frame;
        logic [PA_W-1:0]    paddr;
        fault_level_e       level;
        fault_reason_e      reason;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [FRAME_W-1:0] entry_frame;
    logic [FLAG_W-1:0]  entry_flags;
    logic               unused_entry_bits;
    fault_reason_e      chk_reason;
    logic [PA_W-1:0]    dir_entry_addr;
    logic [PA_W-1:0]    tbl_entry_addr;
    logic [PA_W-1:0]    phys_addr;

    assign entry_frame       = mem_rd_data[ENTRY_W-1 -: FRAME_W];
    assign entry_flags       = mem_rd_data[FLAG_W-1:0];
    assign unused_entry_bits = ^mem_rd_data[ENTRY_W-FRAME_W-1:FLAG_W];

    ptw_addr_gen #(
        .PA_W      (PA_W),
        .DIR_IDX_W (DIR_IDX_W),
        .TBL_IDX_W (TBL_IDX_W),
        .OFF_W     (OFF_W),
        .ENT_LG2   (ENT_LG2)
    ) u_addr_gen (
        .dir_base       (r_q.base),
        .dir_idx        (r_q.vaddr[VA_W-1 -: DIR_IDX_W]),
        .tbl_idx        (r_q.vaddr[OFF_W +: TBL_IDX_W]),
        .page_off       (r_q.vaddr[OFF_W-1:0]),
        .tbl_frame      (r_q.tbl_frame),
        .leaf_frame     (entry_frame),
        .dir_entry_addr (dir_entry_addr),
        .tbl_entry_addr (tbl_entry_addr),
        .phys_addr      (phys_addr)
    );

    ptw_entry_check u_entry_check (
        .flags    (entry_flags),
        .is_write (r_q.is_write),
        .is_user  (r_q.is_user),
        .reason   (chk_reason)
    );

    always_comb begin
        r_d        = r_q;
        req_ready  = 1'b0;
        mem_rd_req = 1'b0;
        mem_addr   = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.vaddr    = req_vaddr;
                    r_d.is_write = req_write;
                    r_d.is_user  = req_user;
                    r_d.base     = dir_base;
                    r_d.paddr    = '0;
                    r_d.level    = LVL_DIR;
                    r_d.reason   = RSN_NONE;
                    r_d.state    = ST_READ_DIR;
                end
            end
            ST_READ_DIR: begin
                mem_rd_req = 1'b1;
                mem_addr   = dir_entry_addr;
                r_d.state  = ST_WAIT_DIR;
            end
            ST_WAIT_DIR: begin
                if (mem_rd_valid) begin
                    if (chk_reason != RSN_NONE) begin
                        r_d.level  = LVL_DIR;
                        r_d.reason = chk_reason;
                        r_d.paddr  = '0;
                        r_d.state  = ST_FAULT;
                    end else begin
                        r_d.tbl_frame = entry_frame;
                        r_d.state     = ST_READ_PT;
                    end
                end
            end
            ST_READ_PT: begin
                mem_rd_req = 1'b1;
                mem_addr   = tbl_entry_addr;
                r_d.state  = ST_WAIT_PT;
            end
            ST_WAIT_PT: begin
                if (mem_rd_valid) begin
                    if (chk_reason != RSN_NONE) begin
                        r_d.level  = LVL_TBL;
                        r_d.reason = chk_reason;
                        r_d.paddr  = '0;
                        r_d.state  = ST_FAULT;
                    end else begin
                        r_d.paddr = phys_addr;
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                if (rsp_ready) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid        = (r_q.state == ST_DONE) || (r_q.state == ST_FAULT);
    assign rsp_fault        = (r_q.state == ST_FAULT);
    assign rsp_paddr        = r_q.paddr;
    assign rsp_fault_level  = r_q.level;
    assign rsp_fault_reason = r_q.reason;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned DIR_IDX_W = 10,
    parameter int unsigned TBL_IDX_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [PA_W-1:0] dir_base,
    input logic            mem_rd_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rd_valid,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic            rsp_fault_level,
    input logic [1:0]      rsp_fault_reason
);

    localparam int unsigned OFF_W = VA_W - DIR_IDX_W - TBL_IDX_W;

    logic [1:0]           rd_cnt;
    logic                 rd_pending;
    logic [DIR_IDX_W-1:0] idx_cap;
    logic [OFF_W-1:0]     off_cap;
    logic [PA_W-1:0]      base_cap;
    logic                 unused_tbl_bits;

    assign unused_tbl_bits = ^req_vaddr[OFF_W +: TBL_IDX_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt     <= '0;
            rd_pending <= 1'b0;
            idx_cap    <= '0;
            off_cap    <= '0;
            base_cap   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                rd_cnt   <= '0;
                idx_cap  <= req_vaddr[VA_W-1 -: DIR_IDX_W];
                off_cap  <= req_vaddr[OFF_W-1:0];
                base_cap <= dir_base;
            end else if (mem_rd_req) begin
                rd_cnt <= rd_cnt + 2'd1;
            end
            if (mem_rd_req) begin
                rd_pending <= 1'b1;
            end else if (mem_rd_valid) begin
                rd_pending <= 1'b0;
            end
        end
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_rd_req && !rd_pending)); // R2

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req); // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pending && !mem_rd_valid) |-> !mem_rd_req); // R10

    AST_DIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && rd_cnt == 2'd0) |-> (mem_addr == base_cap + (PA_W'(idx_cap) << 2))); // R3

    AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_fault_level) |-> (rd_cnt == 2'd1)); // R4

    AST_TBL_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (!rsp_fault || rsp_fault_level)) |-> (rd_cnt == 2'd2)); // R6

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_cap)); // R7

    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_fault_reason != 2'd0 && rsp_paddr == '0)); // R8

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
            && $stable(rsp_fault_level) && $stable(rsp_fault_reason))); // R9

    AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready)); // R9

endmodule

bind ptw_top ptw_checker #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .DIR_IDX_W (DIR_IDX_W),
    .TBL_IDX_W (TBL_IDX_W)
) u_ptw_checker (.*);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = '0;
    logic        mem_rd_req;
    logic [31:0] mem_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_level;
    logic [1:0]  rsp_fault_reason;

    always #5 clk = ~clk;

    ptw_top dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_vaddr        (req_vaddr),
        .req_write        (req_write),
        .req_user         (req_user),
        .dir_base         (dir_base),
        .mem_rd_req       (mem_rd_req),
        .mem_addr         (mem_addr),
        .mem_rd_valid     (mem_rd_valid),
        .mem_rd_data      (mem_rd_data),
        .rsp_valid        (rsp_valid),
        .rsp_ready        (rsp_ready),
        .rsp_paddr        (rsp_paddr),
        .rsp_fault        (rsp_fault),
        .rsp_fault_level  (rsp_fault_level),
        .rsp_fault_reason (rsp_fault_reason)
    );

    logic [31:0] mem_model [0:4095];
    int          n_checks = 0;
    int          n_fails = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [0:3];
    int          lat_cfg = 1;
    int          lat_cnt = 0;
    logic [11:0] pend_idx = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_reason(int f, int wr, int us);
        if ((f & 1) == 0) return 1;
        if (wr != 0 && (f & 2) == 0) return 2;
        if (us != 0 && (f & 4) == 0) return 3;
        return 0;
    endfunction

    // Memory responder: data returns lat_cfg falling edges after the request is seen
    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem_model[pend_idx];
                end
            end
            if (mem_rd_req) begin
                if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
                rd_cnt++;
                pend_idx = mem_addr[13:2];
                lat_cnt  = lat_cfg;
            end
        end
    end

    task automatic run_walk(input int k);
        int pdef, ptef, wr, us, di, ti, off, tf, hold, rd_exp, r_dir, r_tbl, w;
        logic [31:0] pf, db, pde, pte, exp_pa;
        logic exp_fault, exp_level, probe;
        string lt;
        pdef = k & 7;
        ptef = (k >> 3) & 7;
        wr   = (k >> 6) & 1;
        us   = (k >> 7) & 1;
        di   = (k * 37 + 5) & 1023;
        ti   = (k * 91 + 3) & 1023;
        off  = (k * 13 + 7) & 4095;
        tf   = 1 + ((k >> 1) & 1);
        pf   = (k * 32'h1357 + 1) & 32'hFFFFF;
        db   = (((k ^ (k >> 3)) & 1) != 0) ? 32'h3000 : 32'h0;
        hold = (k >> 1) % 3;
        probe = ((k % 4) == 1);
        lat_cfg = 1 + (k % 3);
        pde = (32'(tf) << 12) | (32'(k & 511) << 3) | 32'(pdef);
        pte = (pf << 12) | (32'((k * 5) & 511) << 3) | 32'(ptef);
        mem_model[(db >> 2) + 32'(di)] = pde;
        mem_model[tf * 1024 + ti]      = pte;

        r_dir = exp_reason(pdef, wr, us);
        r_tbl = exp_reason(ptef, wr, us);
        if (r_dir != 0) begin
            exp_fault = 1'b1; exp_level = 1'b0; rd_exp = 1; exp_pa = '0; lt = "R4";
        end else if (r_tbl != 0) begin
            exp_fault = 1'b1; exp_level = 1'b1; rd_exp = 2; exp_pa = '0; lt = "R6";
        end else begin
            exp_fault = 1'b0; exp_level = 1'b0; rd_exp = 2; exp_pa = (pf << 12) | 32'(off); lt = "R7";
        end

        @(negedge clk);
        rd_cnt = 0;
        chk($sformatf("R2 ready when idle k=%0d", k), 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_vaddr = (32'(di) << 22) | (32'(ti) << 12) | 32'(off);
        req_write = wr[0];
        req_user  = us[0];
        dir_base  = db;
        @(negedge clk);
        if (probe) begin
            req_vaddr = ~req_vaddr;
            dir_base  = 32'h0000_1000;
            req_write = ~req_write;
            req_user  = ~req_user;
        end else begin
            req_valid = 1'b0;
        end
        w = 0;
        while (!rsp_valid && w < 60) begin
            if (probe) chk($sformatf("R2 ready low while busy k=%0d", k), 32'(req_ready), 32'd0);
            @(negedge clk);
            w++;
        end
        req_valid = 1'b0;

        chk($sformatf("R3 directory read address k=%0d", k), rd_addr[0], db + 32'(di) * 4);
        if (rd_exp == 2)
            chk($sformatf("R5 table read address k=%0d", k), rd_addr[1], 32'(tf) * 4096 + 32'(ti) * 4);
        chk($sformatf("R10 %s read count k=%0d", lt, k), 32'(rd_cnt), 32'(rd_exp));
        chk($sformatf("R8 %s fault flag k=%0d", lt, k), 32'(rsp_fault), 32'(exp_fault));
        if (exp_fault) begin
            chk($sformatf("R8 %s fault level k=%0d", lt, k), 32'(rsp_fault_level), 32'(exp_level));
            chk($sformatf("R8 %s fault reason k=%0d", lt, k), 32'(rsp_fault_reason),
                32'((r_dir != 0) ? r_dir : r_tbl));
        end
        chk($sformatf("R7 R8 physical address k=%0d", k), rsp_paddr, exp_pa);

        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk($sformatf("R9 valid held k=%0d", k), 32'(rsp_valid), 32'd1);
            chk($sformatf("R9 address held k=%0d", k), rsp_paddr, exp_pa);
            chk($sformatf("R9 fault held k=%0d", k), 32'(rsp_fault), 32'(exp_fault));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk($sformatf("R9 valid dropped k=%0d", k), 32'(rsp_valid), 32'd0);
        chk($sformatf("R9 ready restored k=%0d", k), 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired before the run ended");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem_model[i] = '0;
        for (int i = 0; i < 4; i++) rd_addr[i] = '0;
        repeat (2) @(negedge clk);
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 no response in reset", 32'(rsp_valid), 32'd0);
        chk("R1 no read in reset", 32'(mem_rd_req), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no response after reset", 32'(rsp_valid), 32'd0);
        chk("R1 no read after reset", 32'(mem_rd_req), 32'd0);
        for (int k = 0; k < 256; k++) run_walk(k);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule